// File: doc/BRIEF.md
# Programmable Memory Window Decoder Bank

This block is the address-decode front of a bus target. It holds six base registers, a control word and an identifier word. For every address presented on the bus side, it reports whether the address lands inside one of the enabled windows. If it does, the block also gives the winning window's number and the offset of the address inside that window.

Four general memory windows take their size from a 4-bit code each, packed into the low 16 bits of the control word. The sizes run from 2 GB down to 16 KB. The three smallest sizes also raise a per-window internal-windowing enable. Two further windows give access to register space: one answers I/O cycles and one answers memory cycles. Each has a fixed size set by a parameter and its own enable bit in the control word.

Software programs the bank through a simple configuration write port. The addressed register is visible on a combinational read-back port. Base bits below a window's size are hard-wired to zero, so writing all ones and reading back reveals the size.

Top module: `mwin_decoder_bank`

## Requirements
- R1: After reset, the control word and all base registers read zero, the identifier word reads ID_RESET, no window hits and win_internal is zero.
- R2: Configuration selects are 0 identifier, 1 control, 2 register I/O base, 3 register memory base, and 4..7 memory windows 0..3. Memory window k takes its size code from control bits [4k+3:4k].
- R3: A memory window with code 0 never hits, and its base register reads zero.
- R4: Codes 1 to 12 give a window of 2^(32-code) bytes. Codes 13, 14 and 15 give 64 KB, 32 KB and 16 KB. Base bits below the size are discarded on write and read as zero under the current code.
- R5: win_internal[k] is 1 exactly when window k's code is 13, 14 or 15.
- R6: Control bit 16 enables the register memory window, which is 2^REGMEM_LOG2 bytes. When the bit is clear, that window never hits.
- R7: Control bit 17 enables the register I/O window, which is 2^REGIO_LOG2 bytes. When the bit is clear, the window never hits and its base reads zero. The written value is kept and reappears once the bit is set.
- R8: A write to the identifier word takes effect only if control bit 19 was already set before the write. Otherwise the write is ignored.
- R9: bus_cmd encodes 0 idle, 1 memory, 2 I/O and 3 reserved. I/O commands match only the register I/O window. Memory commands match only the other five windows. Idle and reserved commands never hit.
- R10: Window numbers are 0 register I/O, 1 register memory, and 2+k for memory window k. When several windows match, the lowest number wins. dec_idx carries its number and dec_onehot has only its bit set.
- R11: Decode outputs appear on the clock edge after the address is presented. dec_offset is the address with the bits at and above the winning size cleared. Without a hit, dec_offset, dec_idx and dec_onehot are zero.
- R12: The control word reads back codes in bits [15:0], the enables in bits 16, 17 and 19, and zero in all other bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration register select |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Read-back of the selected register (combinational) |
| bus_cmd | input | 2 | Bus command type |
| bus_addr | input | 32 | Bus address |
| dec_hit | output | 1 | Address hit an enabled window |
| dec_idx | output | 3 | Number of the winning window |
| dec_onehot | output | 6 | One-hot winning window |
| dec_offset | output | 32 | Offset inside the winning window |
| win_internal | output | 4 | Internal-windowing enable per memory window |

## Verification
The embedded properties check the following on every cycle:
- The one-hot result never has more than one bit set.
- A cycle with no hit leaves the offset and index zero.
- Idle cycles never hit.
- A code-0 window never wins.
- A locked identifier word does not change.
- A disabled register I/O base reads zero.
- Reset clears the control word.

Only the bench's scenarios can show that the window sizes, the base masking after an all-ones write, the priority among overlapping windows, the retention of the hidden I/O base and the exact offset values are correct. The bench checks these by comparing against its own model across directed overlaps and random programming.

// File: rtl/mwin_pkg.sv
package mwin_pkg;

    localparam int ADDR_W  = 32;
    localparam int CODE_W  = 4;
    localparam int NUM_MEM = 4;
    localparam int NUM_WIN = NUM_MEM + 2;
    localparam int IDX_W   = $clog2(NUM_WIN);
    localparam int SEL_W   = 3;
    localparam int LG_W    = 6;

    localparam int WIN_REGIO  = 0;
    localparam int WIN_REGMEM = 1;
    localparam int WIN_MEM0   = 2;

    typedef enum logic [1:0] {
        CMD_IDLE = 2'd0,
        CMD_MEM  = 2'd1,
        CMD_IO   = 2'd2,
        CMD_RSVD = 2'd3
    } bus_cmd_e;

    typedef enum logic [SEL_W-1:0] {
        SEL_ID     = 3'd0,
        SEL_CTL    = 3'd1,
        SEL_IOBASE = 3'd2,
        SEL_RMBASE = 3'd3,
        SEL_WIN0   = 3'd4,
        SEL_WIN1   = 3'd5,
        SEL_WIN2   = 3'd6,
        SEL_WIN3   = 3'd7
    } cfg_sel_e;

    localparam int CTL_MEMEN_BIT  = 16;
    localparam int CTL_IOEN_BIT   = 17;
    localparam int CTL_UNLOCK_BIT = 19;

    typedef struct packed {
        logic                                unlock;
        logic                                io_en;
        logic                                mem_en;
        logic [NUM_MEM-1:0][CODE_W-1:0]      codes;
    } ctl_t;

    typedef struct packed {
        logic              en;
        logic              is_io;
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] mask;
    } win_cfg_t;

    // log2 of the window size for a size code; 32 (empty) for code 0
    function automatic logic [LG_W-1:0] code_log2(input logic [CODE_W-1:0] code);
        logic [LG_W-1:0] lg;
        case (code)
            4'd0:    lg = 6'd32;
            4'd13:   lg = 6'd16;
            4'd14:   lg = 6'd15;
            4'd15:   lg = 6'd14;
            default: lg = 6'd32 - {2'b00, code};
        endcase
        return lg;
    endfunction

    function automatic logic code_small(input logic [CODE_W-1:0] code);
        return (code >= 4'd13);
    endfunction

    // ones at and above bit lg; all zero for lg == 32
    function automatic logic [ADDR_W-1:0] upper_mask(input logic [LG_W-1:0] lg);
        logic [ADDR_W:0] one;
        logic [ADDR_W-1:0] low;
        one = (ADDR_W+1)'(1) << lg;
        low = one[ADDR_W-1:0] - 1'b1;
        return ~low;
    endfunction

endpackage

// File: rtl/mwin_cfg_regs.sv
module mwin_cfg_regs
    import mwin_pkg::*;
#(
    parameter logic [ADDR_W-1:0] ID_RESET     = 32'h1A2B_0C3D,
    parameter int                REGIO_LOG2   = 8,
    parameter int                REGMEM_LOG2  = 12
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              cfg_wr,
    input  logic [SEL_W-1:0]                  cfg_sel,
    input  logic [ADDR_W-1:0]                 cfg_wdata,
    output logic [ADDR_W-1:0]                 cfg_rdata,
    output ctl_t                              ctl,
    output logic [ADDR_W-1:0]                 io_base,
    output logic [ADDR_W-1:0]                 rm_base,
    output logic [NUM_MEM-1:0][ADDR_W-1:0]    mem_base,
    output logic [NUM_MEM-1:0][ADDR_W-1:0]    mem_mask
);

    localparam logic [ADDR_W-1:0] IO_MASK = upper_mask(LG_W'(REGIO_LOG2));
    localparam logic [ADDR_W-1:0] RM_MASK = upper_mask(LG_W'(REGMEM_LOG2));

    ctl_t              ctl_q;
    logic [ADDR_W-1:0] id_q;
    logic [ADDR_W-1:0] io_q;
    logic [ADDR_W-1:0] rm_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
            id_q  <= ID_RESET;
            io_q  <= '0;
            rm_q  <= '0;
        end else if (cfg_wr) begin
            case (cfg_sel)
                SEL_CTL: begin
                    ctl_q.unlock <= cfg_wdata[CTL_UNLOCK_BIT];
                    ctl_q.io_en  <= cfg_wdata[CTL_IOEN_BIT];
                    ctl_q.mem_en <= cfg_wdata[CTL_MEMEN_BIT];
                    ctl_q.codes  <= cfg_wdata[NUM_MEM*CODE_W-1:0];
                end
                SEL_ID:     if (ctl_q.unlock) id_q <= cfg_wdata;
                SEL_IOBASE: io_q <= cfg_wdata & IO_MASK;
                SEL_RMBASE: rm_q <= cfg_wdata & RM_MASK;
                default: ;
            endcase
        end
    end

    genvar k;
    generate
        for (k = 0; k < NUM_MEM; k++) begin : g_membase
            logic [ADDR_W-1:0] base_q;
            logic [ADDR_W-1:0] cur_mask;

            assign cur_mask = upper_mask(code_log2(ctl_q.codes[k]));

            always_ff @(posedge clk) begin
                if (rst)
                    base_q <= '0;
                else if (cfg_wr && (cfg_sel == SEL_W'(SEL_WIN0 + k)))
                    base_q <= cfg_wdata & cur_mask;
            end

            assign mem_base[k] = base_q & cur_mask;
            assign mem_mask[k] = cur_mask;
        end
    endgenerate

    always_comb begin
        case (cfg_sel)
            SEL_ID:     cfg_rdata = id_q;
            SEL_CTL:    cfg_rdata = {12'b0, ctl_q.unlock, 1'b0, ctl_q.io_en,
                                     ctl_q.mem_en, ctl_q.codes};
            SEL_IOBASE: cfg_rdata = ctl_q.io_en ? io_q : '0;
            SEL_RMBASE: cfg_rdata = rm_q;
            SEL_WIN0:   cfg_rdata = mem_base[0];
            SEL_WIN1:   cfg_rdata = mem_base[1];
            SEL_WIN2:   cfg_rdata = mem_base[2];
            default:    cfg_rdata = mem_base[3];
        endcase
    end

    assign ctl     = ctl_q;
    assign io_base = io_q;
    assign rm_base = rm_q;

    AST_ID_LOCKED: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && cfg_sel == SEL_ID && !ctl_q.unlock) |=> $stable(id_q)); // R8

    AST_IO_HIDDEN: assert property (@(posedge clk) disable iff (rst)
        (cfg_sel == SEL_IOBASE && !ctl_q.io_en) |-> (cfg_rdata == '0)); // R7

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (ctl_q == '0 && io_q == '0 && rm_q == '0)); // R1

endmodule

// File: rtl/mwin_window_match.sv
module mwin_window_match
    import mwin_pkg::*;
(
    input  win_cfg_t          cfg,
    input  logic [1:0]        cmd,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);

    logic type_ok;

    always_comb begin
        if (cfg.is_io) type_ok = (cmd == CMD_IO);
        else           type_ok = (cmd == CMD_MEM);
        hit = cfg.en && type_ok && ((addr & cfg.mask) == (cfg.base & cfg.mask));
    end

endmodule

// File: rtl/mwin_prio_pick.sv
module mwin_prio_pick #(
    parameter int N     = 6,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     req,
    output logic [N-1:0]     onehot,
    output logic [IDX_W-1:0] idx,
    output logic             any
);

    always_comb begin
        onehot = req & (~req + 1'b1);
        any    = |req;
        idx    = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/mwin_decoder_bank.sv
module mwin_decoder_bank
    import mwin_pkg::*;
#(
    parameter logic [31:0] ID_RESET    = 32'h1A2B_0C3D,
    parameter int          REGIO_LOG2  = 8,
    parameter int          REGMEM_LOG2 = 12
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_wr,
    input  logic [2:0]  cfg_sel,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    input  logic [1:0]  bus_cmd,
    input  logic [31:0] bus_addr,
    output logic        dec_hit,
    output logic [2:0]  dec_idx,
    output logic [5:0]  dec_onehot,
    output logic [31:0] dec_offset,
    output logic [3:0]  win_internal
);

    localparam logic [ADDR_W-1:0] IO_MASK = upper_mask(LG_W'(REGIO_LOG2));
    localparam logic [ADDR_W-1:0] RM_MASK = upper_mask(LG_W'(REGMEM_LOG2));

    ctl_t                           ctl;
    logic [ADDR_W-1:0]              io_base;
    logic [ADDR_W-1:0]              rm_base;
    logic [NUM_MEM-1:0][ADDR_W-1:0] mem_base;
    logic [NUM_MEM-1:0][ADDR_W-1:0] mem_mask;

    mwin_cfg_regs #(
        .ID_RESET    (ID_RESET),
        .REGIO_LOG2  (REGIO_LOG2),
        .REGMEM_LOG2 (REGMEM_LOG2)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .cfg_wr    (cfg_wr),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .ctl       (ctl),
        .io_base   (io_base),
        .rm_base   (rm_base),
        .mem_base  (mem_base),
        .mem_mask  (mem_mask)
    );

    win_cfg_t           wcfg [NUM_WIN];
    logic [NUM_WIN-1:0] req;
    logic [NUM_WIN-1:0] pick;
    logic [IDX_W-1:0]   pick_idx;
    logic               pick_any;

    assign wcfg[WIN_REGIO]  = '{en: ctl.io_en,  is_io: 1'b1, base: io_base, mask: IO_MASK};
    assign wcfg[WIN_REGMEM] = '{en: ctl.mem_en, is_io: 1'b0, base: rm_base, mask: RM_MASK};

    genvar k;
    generate
        for (k = 0; k < NUM_MEM; k++) begin : g_memwin
            assign wcfg[WIN_MEM0+k] = '{en:    (ctl.codes[k] != '0),
                                        is_io: 1'b0,
                                        base:  mem_base[k],
                                        mask:  mem_mask[k]};
            assign win_internal[k] = code_small(ctl.codes[k]);
        end
        for (k = 0; k < NUM_WIN; k++) begin : g_match
            mwin_window_match u_match (
                .cfg  (wcfg[k]),
                .cmd  (bus_cmd),
                .addr (bus_addr),
                .hit  (req[k])
            );
        end
    endgenerate

    mwin_prio_pick #(.N(NUM_WIN), .IDX_W(IDX_W)) u_pick (
        .req    (req),
        .onehot (pick),
        .idx    (pick_idx),
        .any    (pick_any)
    );

    logic [ADDR_W-1:0] win_mask;

    always_comb begin
        win_mask = '0;
        for (int i = 0; i < NUM_WIN; i++) begin
            if (pick[i]) win_mask = win_mask | wcfg[i].mask;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dec_hit    <= 1'b0;
            dec_idx    <= '0;
            dec_onehot <= '0;
            dec_offset <= '0;
        end else begin
            dec_hit    <= pick_any;
            dec_idx    <= pick_any ? pick_idx : '0;
            dec_onehot <= pick;
            dec_offset <= pick_any ? (bus_addr & ~win_mask) : '0;
        end
    end

    AST_ONE_WINNER: assert property (@(posedge clk) disable iff (rst)
        $onehot0(dec_onehot)); // R10

    AST_HIT_MATCHES_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        dec_hit == (dec_onehot != '0)); // R10

    AST_QUIET_WHEN_MISS: assert property (@(posedge clk) disable iff (rst)
        !dec_hit |-> (dec_offset == '0 && dec_idx == '0)); // R11

    AST_IDLE_NO_HIT: assert property (@(posedge clk) disable iff (rst)
        (bus_cmd == CMD_IDLE || bus_cmd == CMD_RSVD) |=> !dec_hit); // R9

    generate
        for (k = 0; k < NUM_MEM; k++) begin : g_chk
            AST_CODE0_SILENT: assert property (@(posedge clk) disable iff (rst)
                (ctl.codes[k] == '0) |=> !dec_onehot[WIN_MEM0+k]); // R3
        end
    endgenerate

endmodule

// File: tb/mwin_decoder_bank_bench.sv
`timescale 1ns/1ps
module mwin_decoder_bank_bench;

    localparam logic [31:0] IDR   = 32'h1A2B_0C3D;
    localparam int          IO_LG = 8;
    localparam int          RM_LG = 12;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr = 1'b0;
    logic [2:0]  cfg_sel = 3'd0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [1:0]  bus_cmd = 2'd0;
    logic [31:0] bus_addr = '0;
    logic        dec_hit;
    logic [2:0]  dec_idx;
    logic [5:0]  dec_onehot;
    logic [31:0] dec_offset;
    logic [3:0]  win_internal;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    mwin_decoder_bank #(.ID_RESET(IDR), .REGIO_LOG2(IO_LG), .REGMEM_LOG2(RM_LG)) u_mwin_decoder_bank (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .bus_cmd(bus_cmd), .bus_addr(bus_addr), .dec_hit(dec_hit),
        .dec_idx(dec_idx), .dec_onehot(dec_onehot), .dec_offset(dec_offset),
        .win_internal(win_internal)
    );

    // bench model
    logic [31:0]      m_id;
    logic [3:0]       m_code [4];
    logic             m_memen, m_ioen, m_unlock;
    logic [31:0]      m_io, m_rm;
    logic [31:0]      m_win [4];

    function automatic int lg_of(input logic [3:0] c);
        if (c == 0)  return 32;
        if (c <= 12) return 32 - int'(c);
        return 16 - (int'(c) - 13);
    endfunction

    function automatic logic [31:0] hi_mask(input int lg);
        if (lg >= 32) return 32'h0;
        return ~((32'h1 << lg) - 32'h1);
    endfunction

    function automatic logic [31:0] model_read(input logic [2:0] s);
        case (s)
            3'd0: return m_id;
            3'd1: return {12'b0, m_unlock, 1'b0, m_ioen, m_memen,
                          m_code[3], m_code[2], m_code[1], m_code[0]};
            3'd2: return m_ioen ? m_io : 32'h0;
            3'd3: return m_rm;
            default: return m_win[s-4] & hi_mask(lg_of(m_code[s-4]));
        endcase
    endfunction

    function automatic string tag_of(input logic [2:0] s);
        case (s)
            3'd0: return "R8 id word";
            3'd1: return "R12 ctl readback";
            3'd2: return "R7 io base";
            3'd3: return "R6 regmem base";
            default: return (m_code[s-4] == 0) ? "R3 disabled base" : "R4 masked base";
        endcase
    endfunction

    function automatic logic [3:0] exp_internal();
        logic [3:0] r;
        for (int k = 0; k < 4; k++) r[k] = (m_code[k] >= 13);
        return r;
    endfunction

    // {hit, idx[2:0], onehot[5:0], offset[31:0]}
    function automatic logic [41:0] exp_dec(input logic [1:0] cmd, input logic [31:0] a);
        for (int w = 0; w < 6; w++) begin
            logic en;
            logic [31:0] b;
            logic [31:0] mk;
            if (w == 0) begin
                en = (cmd == 2'd2) && m_ioen; b = m_io; mk = hi_mask(IO_LG);
            end else if (w == 1) begin
                en = (cmd == 2'd1) && m_memen; b = m_rm; mk = hi_mask(RM_LG);
            end else begin
                en = (cmd == 2'd1) && (m_code[w-2] != 0);
                mk = hi_mask(lg_of(m_code[w-2]));
                b  = m_win[w-2] & mk;
            end
            if (en && ((a & mk) == (b & mk)))
                return {1'b1, 3'(w), 6'(1 << w), a & ~mk};
        end
        return 42'h0;
    endfunction

    task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] s, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = s; cfg_wdata = d;
        @(posedge clk);
        case (s)
            3'd0: if (m_unlock) m_id = d;
            3'd1: begin
                m_unlock = d[19]; m_ioen = d[17]; m_memen = d[16];
                for (int k = 0; k < 4; k++) m_code[k] = d[4*k +: 4];
            end
            3'd2: m_io = d & hi_mask(IO_LG);
            3'd3: m_rm = d & hi_mask(RM_LG);
            default: m_win[s-4] = d & hi_mask(lg_of(m_code[s-4]));
        endcase
        #1 cfg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] s, input string tag);
        @(negedge clk);
        cfg_sel = s;
        #1 chk({32'h0, cfg_rdata}, {32'h0, model_read(s)}, tag);
    endtask

    task automatic dec(input logic [1:0] cmd, input logic [31:0] a, input string tag);
        logic [41:0] e;
        @(negedge clk);
        bus_cmd = cmd; bus_addr = a;
        e = exp_dec(cmd, a);
        @(negedge clk);
        bus_cmd = 2'd0;
        chk({22'h0, dec_hit, dec_idx, dec_onehot, dec_offset}, {22'h0, e}, tag);
    endtask

    task automatic chk_int(input string tag);
        @(negedge clk);
        chk({60'h0, win_internal}, {60'h0, exp_internal()}, tag);
    endtask

    initial begin : watchdog
        #(5.0 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        m_id = IDR; m_memen = 0; m_ioen = 0; m_unlock = 0; m_io = 0; m_rm = 0;
        for (int k = 0; k < 4; k++) begin m_code[k] = 0; m_win[k] = 0; end
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        for (int s = 0; s < 8; s++) rd(3'(s), "R1 reset readback");
        chk_int("R1 reset internal");
        dec(2'd1, 32'h0, "R1 no hit after reset");
        dec(2'd2, 32'h0, "R1 no io hit after reset");

        // R8 locked id write ignored, then unlocked write
        wr(3'd0, 32'hDEAD_BEEF);
        rd(3'd0, "R8 locked id write ignored");
        wr(3'd1, 32'h0008_0000);
        wr(3'd0, 32'hDEAD_BEEF);
        rd(3'd0, "R8 unlocked id write");

        // R4 R5 size probe on window 0 for every code
        for (int c = 0; c < 16; c++) begin
            wr(3'd1, 32'(c));
            wr(3'd4, 32'hFFFF_FFFF);
            rd(3'd4, (c == 0) ? "R3 code0 probe" : "R4 size probe");
            chk_int("R5 internal enable");
        end

        // R2 field position: code only in window 2's field
        wr(3'd1, 32'h0000_0000);
        for (int k = 4; k < 8; k++) wr(3'(k), 32'hFFFF_FFFF);
        wr(3'd1, 32'h0000_0D00);
        for (int k = 4; k < 8; k++) rd(3'(k), "R2 field position");
        chk_int("R2 internal on window 2 only");

        // R7 io base hidden and retained
        wr(3'd1, 32'h0000_0000);
        wr(3'd2, 32'h1234_56FF);
        rd(3'd2, "R7 io base hidden");
        dec(2'd2, 32'h1234_5610, "R7 io disabled no hit");
        wr(3'd1, 32'h0002_0000);
        rd(3'd2, "R7 io base retained");
        dec(2'd2, 32'h1234_5610, "R7 io hit");
        dec(2'd1, 32'h1234_5610, "R9 mem cmd misses io window");
        dec(2'd3, 32'h1234_5610, "R9 reserved cmd no hit");

        // R6 regmem window enable
        wr(3'd3, 32'h4000_0ABC);
        rd(3'd3, "R6 regmem base masked");
        dec(2'd1, 32'h4000_0123, "R6 regmem disabled no hit");
        wr(3'd1, 32'h0001_0000);
        dec(2'd1, 32'h4000_0123, "R6 regmem hit offset");
        dec(2'd2, 32'h4000_0123, "R9 io cmd misses regmem");

        // R10 priority: regmem overlaps window 1; windows 0 and 1 overlap
        wr(3'd1, 32'h0001_00CC);
        wr(3'd4, 32'h4000_0000);
        wr(3'd5, 32'h4000_0000);
        dec(2'd1, 32'h4000_0FF0, "R10 regmem beats windows");
        dec(2'd1, 32'h4000_8FF0, "R10 window0 beats window1");
        wr(3'd1, 32'h0000_00CC);
        dec(2'd1, 32'h4000_0FF0, "R10 window0 wins when regmem off");
        dec(2'd1, 32'h400F_FFFF, "R11 offset at top of window");
        dec(2'd1, 32'h4010_0000, "R11 just outside window");
        dec(2'd0, 32'h4000_0000, "R9 idle no hit");

        // random programming and decoding
        for (int it = 0; it < 40; it++) begin
            wr(3'd1, $urandom & 32'h000B_FFFF);
            chk_int("R5 random internal");
            for (int s = 2; s < 8; s++) wr(3'(s), $urandom);
            if (($urandom & 3) == 0) wr(3'd0, $urandom);
            for (int s = 0; s < 8; s++) rd(3'(s), tag_of(3'(s)));
            for (int j = 0; j < 10; j++) begin
                int t;
                logic [31:0] a;
                logic [1:0] cmd;
                t = int'($urandom % 6);
                if (t == 0) begin
                    a = (m_io & hi_mask(IO_LG)) | ($urandom & ~hi_mask(IO_LG));
                    cmd = 2'd2;
                end else if (t == 1) begin
                    a = m_rm | ($urandom & ~hi_mask(RM_LG));
                    cmd = 2'd1;
                end else begin
                    logic [31:0] mk;
                    mk = hi_mask(lg_of(m_code[t-2]));
                    a = (m_win[t-2] & mk) | ($urandom & ~mk);
                    cmd = 2'd1;
                end
                if (($urandom & 7) == 0) a = $urandom;
                if (($urandom & 15) == 0) cmd = 2'($urandom);
                dec(cmd, a, "R10 random decode");
            end
        end

        // R1 reset again clears programmed state
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        m_id = IDR; m_memen = 0; m_ioen = 0; m_unlock = 0; m_io = 0; m_rm = 0;
        for (int k = 0; k < 4; k++) begin m_code[k] = 0; m_win[k] = 0; end
        for (int s = 0; s < 8; s++) rd(3'(s), "R1 second reset readback");
        chk_int("R1 second reset internal");

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule